// File: doc/BRIEF.md
# Two-Stage Timeout Watchdog

This block is a chipset watchdog that counts down on a tick input from a programmable reload value. The first time the count runs out it raises a timeout flag and, when both a local and a global interrupt enable allow it, holds a system-management interrupt (SMI) request so that a handler can respond. If the count runs out again while the flag is still set and the second stage is armed, the block latches a reboot request. The worst-case hang therefore lasts about two programmed periods.

Software keeps the system alive in one of two ways. It can pulse the keepalive strobe, which reloads the count and disarms the second stage. It can also clear the flag with a write-one-to-clear store, which by itself stops the next expiry from causing a reboot. A halt bit freezes the count. A no-reboot input hides the reboot request at the output, but the flag still behaves as usual.

Top module: `wdt_two_stage`

## Requirements
- R1: After synchronous reset the count equals the parameter RST_RELOAD, the reload register equals RST_RELOAD, the SMI control register reads 0x0000_2001, the timer control register reads 0, the status reads 0, and smi_o and reboot_o are low.
- R2: Each cycle with tick_i high, halt clear and no keepalive decrements the count by one. A tick that finds the count at zero is an expiry, and the count reloads from the reload register, so an expiry comes RELOAD+1 ticks after a load. Cycles without a tick hold the count.
- R3: An expiry while status bit 4 (arm) is clear sets status bit 3 (timeout flag) and bit 4, and does not request a reboot.
- R4: An expiry while both the flag and arm are set latches a reboot request. The request stays until reset, even if the flag is later cleared.
- R5: A status write with bit 3 set clears the flag and arm. With bit 3 clear the write has no effect, and bit 4 cannot be written. Clearing the flag stops the next expiry from rebooting.
- R6: While timer control bit 11 (halt) is set, ticks are ignored: the count holds and no expiry occurs.
- R7: A keepalive pulse loads the count from the reload register and clears arm, leaving the flag unchanged. It takes priority over a tick in the same cycle. The next expiry then acts as a first expiry.
- R8: smi_o is high exactly while the flag is set, SMI control bit 13 (local enable) is 1, and bit 0 (global enable) is 1.
- R9: With the global enable (bit 0) at 0, smi_o stays low whatever bit 13 and the flag hold. All 32 SMI control bits are stored and read back.
- R10: While no_reboot_i is high, reboot_o is low even with a latched request, and the flag is still set by expiries. Dropping no_reboot_i exposes any latched request.
- R11: Writing the reload register does not change the current count. The new value is used at the next expiry or keepalive, up to the all-ones maximum.
- R12: A flag clear in the same cycle as an expiry is applied first, so that expiry acts as a first expiry: the flag and arm end set and there is no reboot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable pulse |
| kick_i | input | 1 | Keepalive strobe |
| no_reboot_i | input | 1 | Masks reboot_o when high |
| smi_ctl_we | input | 1 | SMI control register write strobe |
| smi_ctl_wdata | input | 32 | SMI control write data |
| tmr_ctl_we | input | 1 | Timer control register write strobe |
| tmr_ctl_wdata | input | 16 | Timer control write data |
| sts_we | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wdata | input | 16 | Status write data |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | CNT_W | Reload write data |
| smi_ctl_rdata | output | 32 | SMI control register contents |
| tmr_ctl_rdata | output | 16 | Timer control register contents |
| sts_rdata | output | 16 | Status: bit 3 flag, bit 4 arm |
| rld_rdata | output | CNT_W | Reload register contents |
| count_o | output | CNT_W | Current count |
| smi_o | output | 1 | SMI request level |
| reboot_o | output | 1 | Reboot request |

## Verification
The bench builds the block with CNT_W = 6 and RST_RELOAD = 5. With these values a full period lasts six ticks, so first and second expiries, a keepalive or clear between them, and a clear landing on the exact expiry cycle each fit in a few dozen cycles. The 6-bit width also lets the bench load the all-ones reload value of 63 and follow a whole maximum period to the second expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int SMI_CTL_W    = 32;
    localparam int TMR_CTL_W    = 16;
    localparam int STS_W        = 16;

    localparam int SMI_GLB_BIT  = 0;
    localparam int SMI_LOC_BIT  = 13;
    localparam int HALT_BIT     = 11;
    localparam int STS_TO_BIT   = 3;
    localparam int STS_ARM_BIT  = 4;

    localparam logic [SMI_CTL_W-1:0] SMI_CTL_RST = 32'h0000_2001;
    localparam logic [TMR_CTL_W-1:0] TMR_CTL_RST = '0;

    typedef struct packed {
        logic halt;
        logic smi_loc;
        logic smi_glb;
    } wdt_ctl_t;

    typedef struct packed {
        logic flag;
        logic arm;
        logic reboot;
    } wdt_stage_t;

    function automatic wdt_ctl_t decode_ctl(logic [SMI_CTL_W-1:0] smi,
                                            logic [TMR_CTL_W-1:0] tmr);
        wdt_ctl_t c;
        c.halt    = tmr[HALT_BIT];
        c.smi_loc = smi[SMI_LOC_BIT];
        c.smi_glb = smi[SMI_GLB_BIT];
        return c;
    endfunction

    function automatic logic [STS_W-1:0] pack_status(wdt_stage_t s);
        logic [STS_W-1:0] v;
        v              = '0;
        v[STS_TO_BIT]  = s.flag;
        v[STS_ARM_BIT] = s.arm;
        return v;
    endfunction

endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int unsigned RST_RELOAD = 600
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smi_we,
    input  logic [SMI_CTL_W-1:0] smi_wdata,
    input  logic                 tmr_we,
    input  logic [TMR_CTL_W-1:0] tmr_wdata,
    input  logic                 rld_we,
    input  logic [CNT_W-1:0]     rld_wdata,
    output logic [SMI_CTL_W-1:0] smi_q,
    output logic [TMR_CTL_W-1:0] tmr_q,
    output logic [CNT_W-1:0]     rld_q,
    output wdt_ctl_t             ctl
);
    localparam logic [CNT_W-1:0] RLD_RST = CNT_W'(RST_RELOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_q <= SMI_CTL_RST;
            tmr_q <= TMR_CTL_RST;
            rld_q <= RLD_RST;
        end else begin
            if (smi_we) smi_q <= smi_wdata;
            if (tmr_we) tmr_q <= tmr_wdata;
            if (rld_we) rld_q <= rld_wdata;
        end
    end

    always_comb ctl = decode_ctl(smi_q, tmr_q);

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int CNT_W = 10,
    parameter int unsigned RST_RELOAD = 600
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             halt,
    input  logic             kick,
    input  logic [CNT_W-1:0] rld,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(RST_RELOAD);

    logic step;

    always_comb begin
        step   = tick && !halt && !kick;
        expire = step && (count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= CNT_RST;
        end else if (kick || expire) begin
            count <= rld;
        end else if (step) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/wdt_expiry_stage.sv
module wdt_expiry_stage
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             expire,
    input  logic             kick,
    input  logic             sts_we,
    input  logic [STS_W-1:0] sts_wdata,
    input  wdt_ctl_t         ctl,
    output wdt_stage_t       st,
    output logic             smi
);
    logic clr;
    logic flag_eff;
    logic arm_eff;
    wdt_stage_t st_nx;

    always_comb begin
        clr      = sts_we && sts_wdata[STS_TO_BIT];
        flag_eff = st.flag && !clr;
        arm_eff  = st.arm && !clr && !kick;
        st_nx.flag   = flag_eff;
        st_nx.arm    = arm_eff;
        st_nx.reboot = st.reboot;
        if (expire) begin
            if (flag_eff && arm_eff) st_nx.reboot = 1'b1;
            st_nx.flag = 1'b1;
            st_nx.arm  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nx;
    end

    always_comb smi = st.flag && ctl.smi_loc && ctl.smi_glb;

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int unsigned RST_RELOAD = 600
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 kick_i,
    input  logic                 no_reboot_i,
    input  logic                 smi_ctl_we,
    input  logic [31:0]          smi_ctl_wdata,
    input  logic                 tmr_ctl_we,
    input  logic [15:0]          tmr_ctl_wdata,
    input  logic                 sts_we,
    input  logic [15:0]          sts_wdata,
    input  logic                 rld_we,
    input  logic [CNT_W-1:0]     rld_wdata,
    output logic [31:0]          smi_ctl_rdata,
    output logic [15:0]          tmr_ctl_rdata,
    output logic [15:0]          sts_rdata,
    output logic [CNT_W-1:0]     rld_rdata,
    output logic [CNT_W-1:0]     count_o,
    output logic                 smi_o,
    output logic                 reboot_o
);
    wdt_ctl_t         ctl;
    wdt_stage_t       st;
    logic [CNT_W-1:0] rld_q;
    logic [CNT_W-1:0] count;
    logic             expire;

    wdt_cfg_regs #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .smi_we    (smi_ctl_we),
        .smi_wdata (smi_ctl_wdata),
        .tmr_we    (tmr_ctl_we),
        .tmr_wdata (tmr_ctl_wdata),
        .rld_we    (rld_we),
        .rld_wdata (rld_wdata),
        .smi_q     (smi_ctl_rdata),
        .tmr_q     (tmr_ctl_rdata),
        .rld_q     (rld_q),
        .ctl       (ctl)
    );

    wdt_down_counter #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_i),
        .halt   (ctl.halt),
        .kick   (kick_i),
        .rld    (rld_q),
        .count  (count),
        .expire (expire)
    );

    wdt_expiry_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .kick      (kick_i),
        .sts_we    (sts_we),
        .sts_wdata (sts_wdata),
        .ctl       (ctl),
        .st        (st),
        .smi       (smi_o)
    );

    always_comb begin
        sts_rdata = pack_status(st);
        rld_rdata = rld_q;
        count_o   = count;
        reboot_o  = st.reboot && !no_reboot_i;
    end

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             kick_i,
    input logic             sts_we,
    input logic [15:0]      sts_wdata,
    input logic             halt,
    input logic             expire,
    input logic             flag,
    input logic             arm,
    input logic             reboot,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] rld
);
    a_r3_flag_from_expiry: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(expire));

    a_r4_reboot_sticky: assert property (@(posedge clk) disable iff (rst)
        reboot |=> reboot);

    a_r4_reboot_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(reboot) |-> $past(expire && flag && arm));

    a_r5_clear_flag: assert property (@(posedge clk) disable iff (rst)
        (sts_we && sts_wdata[3] && !expire) |=> !flag);

    a_r6_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (halt && !kick_i) |=> $stable(count));

    a_r7_kick_loads: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> (count == $past(rld)));

endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .kick_i    (kick_i),
    .sts_we    (sts_we),
    .sts_wdata (sts_wdata),
    .halt      (ctl.halt),
    .expire    (expire),
    .flag      (st.flag),
    .arm       (st.arm),
    .reboot    (st.reboot),
    .count     (count),
    .rld       (rld_q)
);

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
    localparam int W   = 6;
    localparam int RLD = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 0, kick_i = 0, no_reboot_i = 0;
    logic smi_ctl_we = 0, tmr_ctl_we = 0, sts_we = 0, rld_we = 0;
    logic [31:0] smi_ctl_wdata = '0;
    logic [15:0] tmr_ctl_wdata = '0, sts_wdata = '0;
    logic [W-1:0] rld_wdata = '0;
    logic [31:0] smi_ctl_rdata;
    logic [15:0] tmr_ctl_rdata, sts_rdata;
    logic [W-1:0] rld_rdata, count_o;
    logic smi_o, reboot_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_two_stage #(.CNT_W(W), .RST_RELOAD(RLD)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .kick_i(kick_i),
        .no_reboot_i(no_reboot_i),
        .smi_ctl_we(smi_ctl_we), .smi_ctl_wdata(smi_ctl_wdata),
        .tmr_ctl_we(tmr_ctl_we), .tmr_ctl_wdata(tmr_ctl_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata),
        .rld_we(rld_we), .rld_wdata(rld_wdata),
        .smi_ctl_rdata(smi_ctl_rdata), .tmr_ctl_rdata(tmr_ctl_rdata),
        .sts_rdata(sts_rdata), .rld_rdata(rld_rdata), .count_o(count_o),
        .smi_o(smi_o), .reboot_o(reboot_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; no_reboot_i = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
        end
        tick_i = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_sts(logic [15:0] v);
        sts_we = 1'b1; sts_wdata = v;
        @(negedge clk);
        sts_we = 1'b0;
    endtask

    task automatic wr_smi(logic [31:0] v);
        smi_ctl_we = 1'b1; smi_ctl_wdata = v;
        @(negedge clk);
        smi_ctl_we = 1'b0;
    endtask

    task automatic wr_tmr(logic [15:0] v);
        tmr_ctl_we = 1'b1; tmr_ctl_wdata = v;
        @(negedge clk);
        tmr_ctl_we = 1'b0;
    endtask

    task automatic wr_rld(logic [W-1:0] v);
        rld_we = 1'b1; rld_wdata = v;
        @(negedge clk);
        rld_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "count", count_o, RLD);
        chk("R1", "reload", rld_rdata, RLD);
        chk("R1", "smi_ctl", smi_ctl_rdata, 32'h0000_2001);
        chk("R1", "tmr_ctl", tmr_ctl_rdata, 0);
        chk("R1", "status", sts_rdata, 0);
        chk("R1", "smi", smi_o, 0);
        chk("R1", "reboot", reboot_o, 0);
    endtask

    task automatic t_count_and_expire();
        do_reset();
        ticks(3);
        chk("R2", "count after 3 ticks", count_o, 2);
        idle(2);
        chk("R2", "count held w/o tick", count_o, 2);
        ticks(2);
        chk("R2", "count at zero", count_o, 0);
        chk("R3", "no flag before expiry", sts_rdata, 0);
        ticks(1);
        chk("R2", "reload at expiry", count_o, RLD);
        chk("R3", "flag+arm after first expiry", sts_rdata, 16'h0018);
        chk("R3", "no reboot at first expiry", reboot_o, 0);
        chk("R8", "smi with flag", smi_o, 1);
        ticks(5);
        chk("R4", "no reboot before 2nd expiry", reboot_o, 0);
        ticks(1);
        chk("R4", "reboot on 2nd expiry", reboot_o, 1);
        wr_sts(16'h0008);
        idle(3);
        chk("R4", "reboot sticky after clear", reboot_o, 1);
    endtask

    task automatic t_w1c();
        do_reset();
        ticks(6);
        wr_sts(16'h0010);
        chk("R5", "write 0 to flag ignored", sts_rdata, 16'h0018);
        wr_sts(16'h0008);
        chk("R5", "write 1 clears", sts_rdata, 0);
        chk("R8", "smi drops with flag", smi_o, 0);
        ticks(6);
        chk("R5", "cleared flag prevents reboot", reboot_o, 0);
        chk("R5", "flag set again", sts_rdata, 16'h0018);
    endtask

    task automatic t_halt();
        do_reset();
        wr_tmr(16'h0800);
        chk("R6", "tmr_ctl readback", tmr_ctl_rdata, 16'h0800);
        ticks(10);
        chk("R6", "count held while halted", count_o, RLD);
        chk("R6", "no expiry while halted", sts_rdata, 0);
        wr_tmr(16'h0000);
        ticks(1);
        chk("R6", "counting resumes", count_o, RLD - 1);
    endtask

    task automatic t_kick();
        do_reset();
        ticks(6);
        ticks(2);
        chk("R7", "count before kick", count_o, 3);
        kick_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0; tick_i = 1'b0;
        chk("R7", "kick reloads over tick", count_o, RLD);
        chk("R7", "kick clears arm keeps flag", sts_rdata, 16'h0008);
        ticks(6);
        chk("R7", "no reboot after kick", reboot_o, 0);
        chk("R7", "re-armed", sts_rdata, 16'h0018);
    endtask

    task automatic t_reload();
        do_reset();
        ticks(2);
        wr_rld(6'h3F);
        chk("R11", "reload readback", rld_rdata, 63);
        chk("R11", "count unaffected by write", count_o, 3);
        ticks(4);
        chk("R11", "new reload used", count_o, 63);
        ticks(63);
        chk("R11", "count reaches zero", count_o, 0);
        chk("R11", "no reboot yet", reboot_o, 0);
        ticks(1);
        chk("R11", "reboot after max period", reboot_o, 1);
    endtask

    task automatic t_smi_enables();
        do_reset();
        ticks(6);
        chk("R8", "smi default enables", smi_o, 1);
        wr_smi(32'h0000_0001);
        chk("R8", "local off", smi_o, 0);
        wr_smi(32'h0000_2000);
        chk("R9", "global off", smi_o, 0);
        wr_smi(32'hFFFF_FFFF);
        chk("R9", "all bits stored", smi_ctl_rdata, 32'hFFFF_FFFF);
        chk("R8", "both on", smi_o, 1);
        wr_smi(32'hFFFF_FFFE);
        chk("R9", "global off with all else", smi_o, 0);
    endtask

    task automatic t_no_reboot();
        do_reset();
        no_reboot_i = 1'b1;
        ticks(12);
        chk("R10", "reboot masked", reboot_o, 0);
        chk("R10", "flag still set", sts_rdata, 16'h0018);
        no_reboot_i = 1'b0;
        idle(1);
        chk("R10", "latched reboot exposed", reboot_o, 1);
    endtask

    task automatic t_clear_on_expiry();
        do_reset();
        ticks(6);
        ticks(5);
        chk("R12", "count at zero", count_o, 0);
        tick_i = 1'b1; sts_we = 1'b1; sts_wdata = 16'h0008;
        @(negedge clk);
        tick_i = 1'b0; sts_we = 1'b0;
        chk("R12", "no reboot", reboot_o, 0);
        chk("R12", "flag and arm set", sts_rdata, 16'h0018);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_count_and_expire();
        t_w1c();
        t_halt();
        t_kick();
        t_reload();
        t_smi_enables();
        t_no_reboot();
        t_clear_on_expiry();
        done = 1;
        report();
    end

    initial begin
        wait (cyc >= 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

endmodule